// File: doc/BRIEF.md
# Free-Running Timer with Two-Pin Edge Capture

This block keeps a 12-bit count of microseconds, taken from a 12 MHz system clock by a divide-by-12 enable. The count runs freely and wraps. Two one-cycle strobes mark time for periodic work. The fast strobe fires each time the low 7 bits of the count roll over to zero, which is every 128 µs. The slow strobe fires each time the low 10 bits roll over, which is every 1.024 ms.

Two input pins are watched for transitions. Each pin owns two 8-bit holding registers: one is written on a low-to-high transition and the other on a high-to-low transition. A shared window select decides which 8 bits of the count are stored, so software can trade resolution against range. Each write sets a sticky flag and gives a one-cycle interrupt pulse for that pin. Software reads the holding registers and the live count through a small read port. Reading a holding register with the read strobe clears its flag.

Top module: `edge_capture_timer`

## Requirements
- R1: While reset is asserted the count, all four holding registers, all flags, both strobes and both interrupt pulses are zero.
- R2: The count advances by one on every 12th rising clock edge after reset is released, the first advance being on the 12th edge. It wraps from 4095 to 0.
- R3: `tick_128us` is high for exactly one cycle, in the cycle in which the count has just advanced to a value whose low 7 bits are zero (every 1536 clocks), and is low otherwise.
- R4: `tick_1ms` is high for exactly one cycle, in the cycle in which the count has just advanced to a value whose low 10 bits are zero (every 12288 clocks). It is always accompanied by `tick_128us`.
- R5: Each pin is sampled on every clock edge. A pin sampled high after being sampled low writes the register at address 2c, where c is the pin index. The opposite transition writes address 2c+1. The value written is taken from the count as it stood just before that edge. A newer write overwrites an older one.
- R6: `win_sel` = n, for n from 0 to 4, stores count bits [n+7:n]. Values 5 to 7 act as 4.
- R7: Every write sets the flag bit `cap_flag[a]` (a = register address) and drives `cap_irq[c]` high for exactly the cycle after the transition edge, which is the same edge at which the register changes.
- R8: `rd_data` returns the holding register, zero-extended, for addresses 0 to 3. It returns the count for address 4 and zero for addresses 5 to 7. `rd_en` at address 0 to 3 clears that flag at the next edge, unless a write to the same register lands on that edge, in which case the flag stays set.
- R9: A write changes only its own register and flag. The other three registers and flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 12 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_pin | input | 2 | Capture inputs, one per channel, synchronous to clk |
| win_sel | input | 3 | Selects which 8-bit window of the count is captured |
| rd_en | input | 1 | Read strobe; clears the flag of the addressed holding register |
| rd_addr | input | 3 | Read address: 0..3 holding registers, 4 live count |
| rd_data | output | 12 | Combinational read data |
| tick_128us | output | 1 | One-cycle strobe every 128 count steps |
| tick_1ms | output | 1 | One-cycle strobe every 1024 count steps |
| cap_flag | output | 4 | Sticky per-register capture flags |
| cap_irq | output | 2 | One-cycle capture pulse per channel |

## Verification
If the clock divider drifts, the count read at address 4 is wrong within 12 clocks, and a strobe arrives out of phase by a multiple of 12 cycles at the next rollover. If the edge detector's stored pin state is corrupted, a capture is either missed or spurious. That shows up on `cap_irq` and `cap_flag` in the very next cycle, and in the stored value. A wrong window shift or a clear that reaches the wrong flag shows up on the first read-back after the affected capture. The unchanged registers are compared on every read-back so that side effects are caught.

// File: rtl/ect_pkg.sv
package ect_pkg;

  localparam int ECT_CNT_W     = 12;
  localparam int ECT_WIN_W     = 8;
  localparam int ECT_CLK_DIV   = 12;
  localparam int ECT_FAST_BITS = 7;
  localparam int ECT_SLOW_BITS = 10;
  localparam int ECT_NCH       = 2;

  // Clamp a window selection to the largest shift that still fits the count.
  function automatic int unsigned clamp_shift(input int unsigned sel,
                                              input int unsigned max_shift);
    return (sel > max_shift) ? max_shift : sel;
  endfunction

  // Register address of a capture slot: two slots per channel, rising first.
  function automatic int unsigned slot_addr(input int unsigned ch,
                                            input bit falling);
    return 2 * ch + (falling ? 1 : 0);
  endfunction

endpackage

// File: rtl/ect_us_div.sv
module ect_us_div #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic us_en
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [DW-1:0] phase_q;

  assign us_en = (phase_q == DW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     phase_q <= '0;
    else if (us_en) phase_q <= '0;
    else            phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/ect_free_cnt.sv
module ect_free_cnt #(
  parameter int CNT_W     = 12,
  parameter int FAST_BITS = 7,
  parameter int SLOW_BITS = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             us_en,
  output logic [CNT_W-1:0] cnt,
  output logic             tick_fast,
  output logic             tick_slow
);
  logic [CNT_W-1:0] cnt_nxt;

  always_comb cnt_nxt = cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      tick_fast <= 1'b0;
      tick_slow <= 1'b0;
    end else if (us_en) begin
      cnt       <= cnt_nxt;
      tick_fast <= (cnt_nxt[FAST_BITS-1:0] == '0);
      tick_slow <= (cnt_nxt[SLOW_BITS-1:0] == '0);
    end else begin
      tick_fast <= 1'b0;
      tick_slow <= 1'b0;
    end
  end
endmodule

// File: rtl/ect_cap_chan.sv
module ect_cap_chan #(
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin,
  input  logic [WIN_W-1:0] win,
  input  logic             clr_rise,
  input  logic             clr_fall,
  output logic [WIN_W-1:0] rise_val,
  output logic [WIN_W-1:0] fall_val,
  output logic             rise_flag,
  output logic             fall_flag,
  output logic             irq,
  output logic             rise_evt,
  output logic             fall_evt
);
  logic pin_q;

  assign rise_evt =  pin & ~pin_q;
  assign fall_evt = ~pin &  pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q     <= 1'b0;
      rise_val  <= '0;
      fall_val  <= '0;
      rise_flag <= 1'b0;
      fall_flag <= 1'b0;
      irq       <= 1'b0;
    end else begin
      pin_q <= pin;
      irq   <= rise_evt | fall_evt;
      if (rise_evt) rise_val <= win;
      if (fall_evt) fall_val <= win;
      if (rise_evt)      rise_flag <= 1'b1;
      else if (clr_rise) rise_flag <= 1'b0;
      if (fall_evt)      fall_flag <= 1'b1;
      else if (clr_fall) fall_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/edge_capture_timer.sv
module edge_capture_timer
  import ect_pkg::*;
#(
  parameter int CNT_W     = ECT_CNT_W,
  parameter int WIN_W     = ECT_WIN_W,
  parameter int CLK_DIV   = ECT_CLK_DIV,
  parameter int FAST_BITS = ECT_FAST_BITS,
  parameter int SLOW_BITS = ECT_SLOW_BITS,
  parameter int NCH       = ECT_NCH,
  localparam int MAX_SH   = CNT_W - WIN_W,
  localparam int SEL_W    = $clog2(MAX_SH + 1),
  localparam int NSLOT    = 2 * NCH,
  localparam int AW       = $clog2(NSLOT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   cap_pin,
  input  logic [SEL_W-1:0] win_sel,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             tick_128us,
  output logic             tick_1ms,
  output logic [NSLOT-1:0] cap_flag,
  output logic [NCH-1:0]   cap_irq
);
  logic             us_en;
  logic [CNT_W-1:0] cnt;
  logic [WIN_W-1:0] win;
  logic [NSLOT-1:0] cap_evt;
  logic [NSLOT-1:0] slot_clr;
  logic [WIN_W-1:0] slot_val [NSLOT];

  ect_us_div #(.DIV(CLK_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .us_en(us_en)
  );

  ect_free_cnt #(.CNT_W(CNT_W), .FAST_BITS(FAST_BITS), .SLOW_BITS(SLOW_BITS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .us_en(us_en), .cnt(cnt),
    .tick_fast(tick_128us), .tick_slow(tick_1ms)
  );

  always_comb win = WIN_W'(cnt >> clamp_shift(int'(win_sel), MAX_SH));

  always_comb begin
    for (int s = 0; s < NSLOT; s++) slot_clr[s] = rd_en && (rd_addr == AW'(s));
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int SR = 2 * c;
    localparam int SF = 2 * c + 1;
    ect_cap_chan #(.WIN_W(WIN_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .pin(cap_pin[c]), .win(win),
      .clr_rise(slot_clr[SR]), .clr_fall(slot_clr[SF]),
      .rise_val(slot_val[SR]), .fall_val(slot_val[SF]),
      .rise_flag(cap_flag[SR]), .fall_flag(cap_flag[SF]),
      .irq(cap_irq[c]),
      .rise_evt(cap_evt[SR]), .fall_evt(cap_evt[SF])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int s = 0; s < NSLOT; s++) begin
      if (rd_addr == AW'(s)) rd_data = CNT_W'(slot_val[s]);
    end
    if (rd_addr == AW'(NSLOT)) rd_data = cnt;
  end
endmodule

// File: rtl/ect_checker.sv
module ect_checker #(
  parameter int CNT_W     = 12,
  parameter int FAST_BITS = 7,
  parameter int NCH       = 2,
  parameter int AW        = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             us_en,
  input logic [CNT_W-1:0] cnt,
  input logic             tick_128us,
  input logic             tick_1ms,
  input logic [2*NCH-1:0] cap_evt,
  input logic [2*NCH-1:0] cap_flag,
  input logic [NCH-1:0]   cap_irq,
  input logic             rd_en,
  input logic [AW-1:0]    rd_addr
);
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    us_en |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !us_en |=> $stable(cnt));

  a_r3_fast_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    tick_128us |-> (cnt[FAST_BITS-1:0] == '0));

  a_r3_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    tick_128us |=> !tick_128us);

  a_r4_slow_with_fast: assert property (@(posedge clk) disable iff (!rst_n)
    tick_1ms |-> tick_128us);

  for (genvar s = 0; s < 2*NCH; s++) begin : g_slot
    a_r7_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt[s] |=> cap_flag[s]);
    a_r8_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr == AW'(s) && !cap_evt[s]) |=> !cap_flag[s]);
  end

  for (genvar c = 0; c < NCH; c++) begin : g_irq
    a_r7_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_evt[2*c] || cap_evt[2*c+1]) |=> cap_irq[c]);
    a_r7_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !(cap_evt[2*c] || cap_evt[2*c+1]) |=> !cap_irq[c]);
  end
endmodule

bind edge_capture_timer ect_checker #(
  .CNT_W(CNT_W), .FAST_BITS(FAST_BITS), .NCH(NCH), .AW(AW)
) u_ect_checker (
  .clk(clk), .rst_n(rst_n), .us_en(us_en), .cnt(cnt),
  .tick_128us(tick_128us), .tick_1ms(tick_1ms),
  .cap_evt(cap_evt), .cap_flag(cap_flag), .cap_irq(cap_irq),
  .rd_en(rd_en), .rd_addr(rd_addr)
);

// File: tb/edge_capture_timer_bench.sv
module edge_capture_timer_bench;
  localparam int CLK_P = 84;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cap_pin = '0;
  logic [2:0]  win_sel = '0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic [11:0] rd_data;
  logic        tick_128us, tick_1ms;
  logic [3:0]  cap_flag;
  logic [1:0]  cap_irq;

  int compared = 0;
  int mismatched = 0;
  int ecount = 0;
  bit done = 0;

  typedef struct { int addr; int val; } exp_t;
  exp_t sb_q[$];
  int   shadow [4];
  logic [3:0] exp_flag = '0;

  edge_capture_timer u_edge_capture_timer (
    .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .win_sel(win_sel),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .tick_128us(tick_128us), .tick_1ms(tick_1ms),
    .cap_flag(cap_flag), .cap_irq(cap_irq)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) if (rst_n) ecount <= ecount + 1;

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Tick monitor: R3 every 1536 clocks, R4 every 12288 clocks
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit e_fast, e_slow;
      e_fast = (ecount > 0) && (ecount % 1536 == 0);
      e_slow = (ecount > 0) && (ecount % 12288 == 0);
      if (e_fast || tick_128us) chk("R3 tick_128us", int'(tick_128us), int'(e_fast));
      if (e_slow || tick_1ms)   chk("R4 tick_1ms", int'(tick_1ms), int'(e_slow));
    end
  end

  function automatic int model_count();
    return (ecount / 12) % 4096;
  endfunction

  task automatic read_count(input string req);
    rd_addr = 3'd4;
    #1;
    chk(req, int'(rd_data), model_count());
  endtask

  // Driver: called at a negedge; toggles a pin and pushes the expected capture
  task automatic cap_edge(input int c, input bit rising);
    exp_t e;
    int sh;
    sh = (int'(win_sel) > 4) ? 4 : int'(win_sel);
    e.addr = 2 * c + (rising ? 0 : 1);
    e.val  = (model_count() >> sh) & 255;
    cap_pin[c] = rising;
    sb_q.push_back(e);
    shadow[e.addr] = e.val;
    exp_flag[e.addr] = 1'b1;
    @(negedge clk);
    chk("R7 irq pulse", int'(cap_irq), 1 << c);
    chk("R7 flag set", int'(cap_flag), int'(exp_flag));
    @(negedge clk);
    chk("R7 irq one cycle", int'(cap_irq), 0);
  endtask

  // Monitor: pops expected captures and compares through the read port
  task automatic drain();
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      rd_addr = 3'(e.addr);
      #1;
      chk("R5 R6 capture value", int'(rd_data), e.val);
    end
    for (int a = 0; a < 4; a++) begin
      rd_addr = 3'(a);
      #1;
      chk("R9 other registers", int'(rd_data), shadow[a]);
    end
    chk("R9 flags", int'(cap_flag), int'(exp_flag));
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    for (int a = 0; a < 4; a++) shadow[a] = 0;
    // R1 reset state
    wait_cyc(3);
    for (int a = 0; a < 5; a++) begin
      rd_addr = 3'(a);
      #1;
      chk("R1 reset read", int'(rd_data), 0);
    end
    chk("R1 reset flags", int'(cap_flag), 0);
    chk("R1 reset ticks", int'({tick_128us, tick_1ms, cap_irq}), 0);
    rst_n = 1'b1;

    // R2 counting cadence
    wait_cyc(11);
    read_count("R2 before first step");
    wait_cyc(1);
    read_count("R2 first step");
    wait_cyc(500);
    read_count("R2 count");

    // R5 R6 captures under several windows
    win_sel = 3'd0; cap_edge(0, 1'b1); drain();
    wait_cyc(777);
    win_sel = 3'd2; cap_edge(0, 1'b0); drain();
    wait_cyc(2000);
    win_sel = 3'd4; cap_edge(1, 1'b1); drain();
    wait_cyc(3100);
    win_sel = 3'd7; cap_edge(1, 1'b0); drain();   // R6 clamp to 4
    wait_cyc(1234);
    win_sel = 3'd3; cap_edge(0, 1'b1); drain();   // R5 overwrite
    wait_cyc(5);

    // R8 read clears the addressed flag only
    rd_addr = 3'd0; rd_en = 1'b1;
    #1;
    chk("R8 read slot 0", int'(rd_data), shadow[0]);
    @(negedge clk);
    rd_en = 1'b0;
    exp_flag[0] = 1'b0;
    chk("R8 flag cleared", int'(cap_flag), int'(exp_flag));

    // R8 collision: clear and capture on the same edge, capture wins
    begin
      exp_t e;
      win_sel = 3'd1;
      rd_addr = 3'd1; rd_en = 1'b1;
      e.addr = 1;
      e.val  = (model_count() >> 1) & 255;
      cap_pin[0] = 1'b0;
      sb_q.push_back(e);
      shadow[1] = e.val;
      exp_flag[1] = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      chk("R8 collision flag", int'(cap_flag), int'(exp_flag));
      drain();
    end

    // R8 unused addresses read zero
    for (int a = 5; a < 8; a++) begin
      rd_addr = 3'(a);
      #1;
      chk("R8 unused address", int'(rd_data), 0);
    end

    // R2 wrap past 4095
    while (ecount < 49140) @(negedge clk);
    read_count("R2 near wrap");
    while (ecount < 49160) @(negedge clk);
    read_count("R2 after wrap");
    wait_cyc(40);
    read_count("R2 after wrap later");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      done = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule